// File: doc/BRIEF.md
# Serial Trim and Option Loader

This block lets a production tester set the reference trims and mode options of a power-supply supervisor over two pins that serve other roles in normal operation. While the programming-mode input is high, the pin that normally reports power good carries serial data. The pin that normally switches the main converter on and off carries the serial clock. Outside programming mode, edges on those two pins have no effect on the block.

Each frame is eight bits long and is shifted in most significant bit first, one bit per falling clock edge. The upper nibble is the value and the lower nibble selects a parameter class. An accepted frame updates a volatile register array, and that array drives the trim and option outputs. The volatile array can be rewritten freely and returns to its defaults whenever supply undervoltage lockout is asserted. A dedicated burn frame copies the volatile array once into a permanent bank. From then on the outputs follow the permanent bank.

The serial pins are asynchronous to the system clock. They pass through a synchroniser of parameterised depth before any edge is detected.

Top module: `trim_loader`

## Requirements
- R1: After reset the three reference trims, the AC threshold trim and the hysteresis trim read 1000 (the nominal code). All four option bits read 0, which selects latch mode, 12V monitor on, 5V monitor on and the 5V auxiliary threshold. The burned flag reads 0.
- R2: While the programming-mode input is high, a frame is taken on falling serial-clock edges, most significant bit first. Its bits 7..4 are the value and its bits 3..0 are the class. The frame is applied when its eighth bit arrives. The classes are: 1 for the main reference, 2 for the 3.3V reference, 3 for the auxiliary reference, 4 for the AC threshold and 5 for the hysteresis. A later frame to the same class overwrites the earlier one.
- R3: Class 6 sets the options from the value bits. Value bit 0 selects bounce mode, bit 1 disables the 12V monitor, bit 2 disables the 5V monitor and bit 3 selects the 3.3V auxiliary threshold.
- R4: Serial-clock edges while the programming-mode input is low change no output.
- R5: A partial frame is discarded when the programming-mode input falls. The next frame after re-entry is framed from its first bit.
- R6: Frames with class 0 or class 7 to 15 change no output. The one exception is the burn frame.
- R7: The frame 00001111 sets the burned flag and copies the volatile array into the permanent bank. From then on the outputs come from the permanent bank, and later frames change no output.
- R8: Undervoltage lockout returns the volatile array to its defaults and discards a partial frame. It leaves the permanent bank and the burned flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| uvlo_i | input | 1 | Supply undervoltage lockout, synchronous, active high |
| prog_i | input | 1 | Programming-mode select, asynchronous |
| sdat_i | input | 1 | Serial data (shared power-good pin), asynchronous |
| sclk_i | input | 1 | Serial clock (shared on/off pin), asynchronous |
| ref_a_trim_o | output | 4 | Main error-amplifier reference trim |
| ref_b_trim_o | output | 4 | 3.3V error-amplifier reference trim |
| ref_c_trim_o | output | 4 | Auxiliary error-amplifier reference trim |
| ac_thr_trim_o | output | 4 | AC-sense threshold trim |
| ac_hys_trim_o | output | 4 | AC-sense hysteresis current trim |
| opt_bounce_o | output | 1 | 1 = auto-restart after undervoltage, 0 = latch |
| opt_no12_o | output | 1 | 1 = 12V monitor disabled |
| opt_no5_o | output | 1 | 1 = 5V monitor disabled |
| opt_aux33_o | output | 1 | 1 = auxiliary monitor uses 3.3V thresholds |
| burned_o | output | 1 | Permanent bank has been written |

## Verification
A bit counter that slips shows up at the next frame: the value lands in the wrong class, or a nibble is shifted, and the outputs show this a few system clocks after the eighth falling edge. A volatile array that missed a lockout clear shows stale trims on the cycle after lockout. A burn that is not sticky shows up later, when a frame sent after the burn moves an output that should have stayed frozen. The bench therefore compares every output after every frame, mode change and lockout pulse.

// File: rtl/trim_pkg.sv
package trim_pkg;
   // Parameter class codes carried in the low nibble of a frame
   localparam logic [3:0] CLS_REF_A  = 4'd1;
   localparam logic [3:0] CLS_REF_B  = 4'd2;
   localparam logic [3:0] CLS_REF_C  = 4'd3;
   localparam logic [3:0] CLS_AC_THR = 4'd4;
   localparam logic [3:0] CLS_AC_HYS = 4'd5;
   localparam logic [3:0] CLS_OPTS   = 4'd6;
   localparam int unsigned NUM_CLS   = 6;

   // Option bit positions inside the class-6 value
   localparam int unsigned OPT_BOUNCE = 0;
   localparam int unsigned OPT_NO12   = 1;
   localparam int unsigned OPT_NO5    = 2;
   localparam int unsigned OPT_AUX33  = 3;

   typedef enum logic [1:0] {
      BANK_OP_IDLE  = 2'd0,
      BANK_OP_WRITE = 2'd1,
      BANK_OP_BURN  = 2'd2,
      BANK_OP_CLEAR = 2'd3
   } bank_op_e;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("trim_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/trim_deser.sv
module trim_deser #(
   parameter int unsigned FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               bit_stb_i,
   input  logic               bit_i,
   output logic               frame_vld_o,
   output logic [FRAME_W-1:0] frame_o
);
   localparam int unsigned CNT_W = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("trim_deser: FRAME_W must be at least 2");
   end

   logic [FRAME_W-2:0] shift_q;
   logic [CNT_W-1:0]   cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q     <= '0;
         cnt_q       <= '0;
         frame_vld_o <= 1'b0;
         frame_o     <= '0;
      end else if (clr_i) begin
         shift_q     <= '0;
         cnt_q       <= '0;
         frame_vld_o <= 1'b0;
      end else begin
         frame_vld_o <= 1'b0;
         if (bit_stb_i) begin
            shift_q <= {shift_q[FRAME_W-3:0], bit_i};
            if (cnt_q == LAST_BIT) begin
               cnt_q       <= '0;
               frame_vld_o <= 1'b1;
               frame_o     <= {shift_q, bit_i};
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/trim_bank.sv
module trim_bank
   import trim_pkg::*;
#(
   parameter int unsigned DATA_W   = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned CLASSES  = NUM_CLS,
   parameter int unsigned OPT_CLS  = 6,
   parameter logic [DATA_W-1:0] NOM_CODE = DATA_W'(1 << (DATA_W - 1))
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             uvlo_i,
   input  logic                             frame_vld_i,
   input  logic [DATA_W-1:0]                data_i,
   input  logic [ADDR_W-1:0]                addr_i,
   output logic [CLASSES-1:0][DATA_W-1:0]   view_o,
   output logic                             burned_o
);
   if (CLASSES >= (1 << ADDR_W) - 1) begin : g_bad_classes
      $error("trim_bank: class codes collide with the burn address");
   end

   bank_op_e op;
   logic     is_burn;

   assign is_burn = (addr_i == {ADDR_W{1'b1}}) && (data_i == '0);

   always_comb begin
      op = BANK_OP_IDLE;
      if (uvlo_i) begin
         op = BANK_OP_CLEAR;
      end else if (frame_vld_i) begin
         if (is_burn) begin
            op = burned_o ? BANK_OP_IDLE : BANK_OP_BURN;
         end else begin
            op = BANK_OP_WRITE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burned_o <= 1'b0;
      end else if (op == BANK_OP_BURN) begin
         burned_o <= 1'b1;
      end
   end

   for (genvar k = 0; k < CLASSES; k++) begin : g_cls
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(k + 1);
      localparam logic [DATA_W-1:0] DFLT    = ((k + 1) == OPT_CLS) ? '0 : NOM_CODE;

      logic [DATA_W-1:0] vol_q;
      logic [DATA_W-1:0] nv_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vol_q <= DFLT;
         end else if (op == BANK_OP_CLEAR) begin
            vol_q <= DFLT;
         end else if (op == BANK_OP_WRITE && addr_i == MY_ADDR) begin
            vol_q <= data_i;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            nv_q <= DFLT;
         end else if (op == BANK_OP_BURN) begin
            nv_q <= vol_q;
         end
      end

      assign view_o[k] = burned_o ? nv_q : vol_q;
   end
endmodule

// File: rtl/trim_loader.sv
module trim_loader
   import trim_pkg::*;
#(
   parameter int unsigned DATA_W      = 4,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uvlo_i,
   input  logic              prog_i,
   input  logic              sdat_i,
   input  logic              sclk_i,
   output logic [DATA_W-1:0] ref_a_trim_o,
   output logic [DATA_W-1:0] ref_b_trim_o,
   output logic [DATA_W-1:0] ref_c_trim_o,
   output logic [DATA_W-1:0] ac_thr_trim_o,
   output logic [DATA_W-1:0] ac_hys_trim_o,
   output logic              opt_bounce_o,
   output logic              opt_no12_o,
   output logic              opt_no5_o,
   output logic              opt_aux33_o,
   output logic              burned_o
);
   localparam int unsigned FRAME_W = DATA_W + ADDR_W;

   if (DATA_W < 4) begin : g_bad_data
      $error("trim_loader: DATA_W must hold the four option bits");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("trim_loader: ADDR_W must cover six classes and the burn code");
   end

   logic               prog_s;
   logic               sdat_s;
   logic               sclk_s;
   logic               sclk_prev;
   logic               bit_stb;
   logic               frame_vld;
   logic [FRAME_W-1:0] frame_q;
   logic [NUM_CLS-1:0][DATA_W-1:0] view;

   trim_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({prog_i, sdat_i, sclk_i}),
      .q_o   ({prog_s, sdat_s, sclk_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b1;
      end else begin
         sclk_prev <= sclk_s;
      end
   end

   assign bit_stb = prog_s && sclk_prev && !sclk_s;

   trim_deser #(.FRAME_W(FRAME_W)) u_deser (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (uvlo_i || !prog_s),
      .bit_stb_i   (bit_stb),
      .bit_i       (sdat_s),
      .frame_vld_o (frame_vld),
      .frame_o     (frame_q)
   );

   trim_bank #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .CLASSES (NUM_CLS),
      .OPT_CLS (int'(CLS_OPTS))
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .uvlo_i      (uvlo_i),
      .frame_vld_i (frame_vld),
      .data_i      (frame_q[FRAME_W-1:ADDR_W]),
      .addr_i      (frame_q[ADDR_W-1:0]),
      .view_o      (view),
      .burned_o    (burned_o)
   );

   assign ref_a_trim_o  = view[CLS_REF_A  - 1];
   assign ref_b_trim_o  = view[CLS_REF_B  - 1];
   assign ref_c_trim_o  = view[CLS_REF_C  - 1];
   assign ac_thr_trim_o = view[CLS_AC_THR - 1];
   assign ac_hys_trim_o = view[CLS_AC_HYS - 1];
   assign opt_bounce_o  = view[CLS_OPTS - 1][OPT_BOUNCE];
   assign opt_no12_o    = view[CLS_OPTS - 1][OPT_NO12];
   assign opt_no5_o     = view[CLS_OPTS - 1][OPT_NO5];
   assign opt_aux33_o   = view[CLS_OPTS - 1][OPT_AUX33];
endmodule

// File: rtl/trim_loader_chk.sv
module trim_loader_chk #(
   parameter int unsigned DATA_W = 4,
   parameter int unsigned ADDR_W = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     uvlo_i,
   input logic                     prog_s,
   input logic                     frame_vld,
   input logic [DATA_W+ADDR_W-1:0] frame_q,
   input logic                     burned_o,
   input logic [DATA_W-1:0]        ref_a_trim_o,
   input logic [DATA_W-1:0]        ref_b_trim_o,
   input logic [DATA_W-1:0]        ref_c_trim_o,
   input logic [DATA_W-1:0]        ac_thr_trim_o,
   input logic [DATA_W-1:0]        ac_hys_trim_o,
   input logic                     opt_bounce_o,
   input logic                     opt_no12_o,
   input logic                     opt_no5_o,
   input logic                     opt_aux33_o
);
   localparam logic [DATA_W-1:0] NOM = DATA_W'(1 << (DATA_W - 1));

   logic [5*DATA_W+3:0] outs;
   logic [ADDR_W-1:0]   cls;
   assign outs = {ref_a_trim_o, ref_b_trim_o, ref_c_trim_o, ac_thr_trim_o,
                  ac_hys_trim_o, opt_bounce_o, opt_no12_o, opt_no5_o, opt_aux33_o};
   assign cls  = frame_q[ADDR_W-1:0];

   AST_BURN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      burned_o |=> burned_o);  // R7

   AST_BURNED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      burned_o |=> $stable(outs));  // R7

   AST_PROG_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_s && $past(!prog_s) && !uvlo_i) |=> $stable(outs));  // R4

   AST_UVLO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (uvlo_i && !burned_o) |=> (ref_a_trim_o == NOM && ac_hys_trim_o == NOM
                                 && !opt_bounce_o && !opt_aux33_o));  // R8

   AST_UNUSED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && !uvlo_i && (cls == '0 || cls > ADDR_W'(6))) |=> $stable(outs));  // R6
endmodule

bind trim_loader trim_loader_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .uvlo_i        (uvlo_i),
   .prog_s        (prog_s),
   .frame_vld     (frame_vld),
   .frame_q       (frame_q),
   .burned_o      (burned_o),
   .ref_a_trim_o  (ref_a_trim_o),
   .ref_b_trim_o  (ref_b_trim_o),
   .ref_c_trim_o  (ref_c_trim_o),
   .ac_thr_trim_o (ac_thr_trim_o),
   .ac_hys_trim_o (ac_hys_trim_o),
   .opt_bounce_o  (opt_bounce_o),
   .opt_no12_o    (opt_no12_o),
   .opt_no5_o     (opt_no5_o),
   .opt_aux33_o   (opt_aux33_o)
);

// File: tb/sim_trim_loader.sv
`timescale 1ns/1ps
module sim_trim_loader;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uvlo = 1'b0, prog = 1'b0, sdat = 1'b0, sclk = 1'b1;
   logic [3:0] ra, rb, rc, at, ah;
   logic ob, n12, n5, a33, burned;

   always #2.5 clk = ~clk;

   trim_loader u0 (
      .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .prog_i(prog), .sdat_i(sdat), .sclk_i(sclk),
      .ref_a_trim_o(ra), .ref_b_trim_o(rb), .ref_c_trim_o(rc),
      .ac_thr_trim_o(at), .ac_hys_trim_o(ah),
      .opt_bounce_o(ob), .opt_no12_o(n12), .opt_no5_o(n5), .opt_aux33_o(a33),
      .burned_o(burned)
   );

   typedef struct {
      logic [24:0] v;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0, fails = 0;
   bit done = 1'b0;

   // Reference model
   logic [3:0] m_vol [1:6];
   logic [3:0] m_nv  [1:6];
   bit         m_burned;

   function automatic void model_reset_vol();
      for (int k = 1; k <= 5; k++) m_vol[k] = 4'b1000;
      m_vol[6] = 4'b0000;
   endfunction

   function automatic void model_apply(input logic [7:0] f);
      if (f == 8'h0F) begin
         if (!m_burned) begin
            for (int k = 1; k <= 6; k++) m_nv[k] = m_vol[k];
            m_burned = 1'b1;
         end
      end else if (f[3:0] >= 4'd1 && f[3:0] <= 4'd6) begin
         m_vol[f[3:0]] = f[7:4];
      end
   endfunction

   function automatic logic [24:0] model_view();
      logic [24:0] v;
      v[24] = m_burned;
      for (int k = 1; k <= 6; k++)
         v[(6-k)*4 +: 4] = m_burned ? m_nv[k] : m_vol[k];
      return v;
   endfunction

   task automatic expect_now(input string tag);
      item_t it;
      it.v   = model_view();
      it.tag = tag;
      q.push_back(it);
      @(posedge clk);
      @(posedge clk);
   endtask

   // Monitor: pops expectations and compares at the falling clock edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [24:0] act;
         it  = q.pop_front();
         act = {burned, ra, rb, rc, at, ah, a33, n5, n12, ob};
         checks++;
         if (act !== it.v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.v);
         end
      end
   end

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         sdat = b[7-i];
         repeat (4) @(posedge clk);
         sclk = 1'b0;
         repeat (8) @(posedge clk);
         sclk = 1'b1;
         repeat (4) @(posedge clk);
      end
   endtask

   task automatic send_frame(input logic [3:0] d, input logic [3:0] a, input string tag);
      send_bits({d, a}, 8);
      repeat (10) @(posedge clk);
      if (prog) model_apply({d, a});
      expect_now(tag);
   endtask

   task automatic set_prog(input logic v);
      prog = v;
      repeat (6) @(posedge clk);
   endtask

   task automatic pulse_uvlo(input string tag);
      @(posedge clk);
      uvlo = 1'b1;
      @(posedge clk);
      uvlo = 1'b0;
      repeat (4) @(posedge clk);
      model_reset_vol();
      expect_now(tag);
   endtask

   initial begin
      model_reset_vol();
      for (int k = 1; k <= 6; k++) m_nv[k] = m_vol[k];
      m_burned = 1'b0;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);
      expect_now("R1 reset defaults");

      set_prog(1'b1);
      send_frame(4'h3, 4'd1, "R2 main ref write");
      send_frame(4'hA, 4'd2, "R2 3v3 ref write");
      send_frame(4'h5, 4'd3, "R2 aux ref write");
      send_frame(4'hC, 4'd4, "R2 ac threshold write");
      send_frame(4'h1, 4'd5, "R2 hysteresis write");
      send_frame(4'hE, 4'd1, "R2 main ref rewrite");
      send_frame(4'b0101, 4'd6, "R3 bounce and 5V disable");
      send_frame(4'b1010, 4'd6, "R3 12V disable and aux 3v3");

      set_prog(1'b0);
      send_frame(4'hB, 4'd1, "R4 clock ignored without prog");
      set_prog(1'b1);

      send_bits(8'hFF, 5);
      set_prog(1'b0);
      set_prog(1'b1);
      send_frame(4'h7, 4'd2, "R5 partial frame dropped");

      send_frame(4'hF, 4'd0, "R6 class 0 ignored");
      send_frame(4'h3, 4'd7, "R6 class 7 ignored");
      send_frame(4'h5, 4'd15, "R6 class 15 ignored");

      pulse_uvlo("R8 lockout restores defaults");
      send_frame(4'h2, 4'd1, "R8 write after lockout");
      send_bits(8'hFF, 3);
      pulse_uvlo("R8 lockout with partial frame");
      send_frame(4'h9, 4'd3, "R8 framing restarts after lockout");
      send_frame(4'h4, 4'd5, "R2 hysteresis before burn");

      send_frame(4'h0, 4'hF, "R7 burn sets flag");
      send_frame(4'h6, 4'd1, "R7 write after burn frozen");
      send_frame(4'h0, 4'hF, "R7 second burn no effect");
      pulse_uvlo("R8 permanent bank kept");

      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule